// File: doc/BRIEF.md
# Shared-Port Pipeline Fetch Arbiter

This block is the control skeleton of a four-stage in-order pipeline (fetch, decode, execute, write). Instruction fetch and the final write stage share one single-ported memory, which can serve only one access per clock. Every cycle the block decides who owns the port. A write stage that stores to memory always wins. In that cycle fetch is held, the waiting instruction stays at the head of the instruction source, and an empty slot (a bubble) enters decode in its place.

Instructions are abstract tokens. Each carries a valid bit, a one-bit "stores to memory" flag and a sequence number, which is also its fetch address. The three stages behind fetch advance every cycle without condition, so a conflicting store always drains. A free-running cycle counter and a retired-instruction counter let a bench measure how long a sequence takes. Five back-to-back register-only instructions finish in 8 cycles. Five storing instructions finish in 11.

Top module: `fetch_stall_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the decode, execute and write stage valid bits, the cycle counter and the retired counter. A fetch may take place in the first cycle after reset is released.
- R2: At most one memory access is issued per cycle. `mem_we` is high only for a write-stage store, never for a fetch.
- R3: When the write stage holds a valid instruction with its store flag set, that store owns the port: `mem_en`=1, `mem_we`=1, `mem_addr` = 0x800 + the token. In that cycle `fetch_ack` is 0 even if `instr_avail` is 1.
- R4: When no fetch happens in a cycle, decode holds a bubble (valid 0) in the next cycle. Decode, execute and write advance one stage every cycle, stall or not.
- R5: Fetched tokens are consecutive integers from 0 after reset. A held instruction keeps its token and is fetched before any younger one. With three storing instructions at the head of the stream, token 3 is fetched in cycle index 6 (counting from 0 after reset).
- R6: If the write stage is empty or does not store, an available instruction is fetched that cycle: `fetch_ack`=1, `mem_en`=1, `mem_we`=0, `mem_addr` = the token.
- R7: With `instr_avail` low and no store in the write stage, no memory access is issued and a bubble is inserted.
- R8: `cycle_cnt` increments every cycle. `retired_cnt` increments once for each valid instruction in the write stage. Five non-storing instructions offered back to back reach `retired_cnt`=5 when `cycle_cnt`=8. Five storing ones reach it at 11. When only the first stores, they reach it at 9.
- R9: `stg_valid` and `stg_tok` use lane 0 = fetch, 1 = decode, 2 = execute, 3 = write. Lane k's token is `stg_tok[k*12 +: 12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_avail | input | 1 | An instruction is ready to be fetched |
| instr_wr | input | 1 | The offered instruction stores to memory in its last stage |
| fetch_ack | output | 1 | The offered instruction is fetched this cycle |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write-stage store |
| mem_addr | output | 12 | Fetch address or store address |
| stg_valid | output | 4 | Per-lane valid bits |
| stg_tok | output | 48 | Per-lane tokens, 12 bits each |
| cycle_cnt | output | 16 | Cycles since reset |
| retired_cnt | output | 16 | Instructions that left the write stage |

## Verification
The hardest state to reach is a run of stalls: several storing instructions arrive at the write stage back to back while the source keeps offering the same held instruction, sometimes with gaps in availability that overlap the stall. Directed streams with every instruction storing produce the three-cycle hold and the 11-cycle total. Seeded random streams with a heavy store bias and random availability gaps mix stalls, bubbles and register-only retirements. Every cycle is compared against a bench-side schedule that records when each token reaches the write stage.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int ADDR_W = 12;

  typedef struct packed {
    logic              valid;
    logic              wr;
    logic [ADDR_W-1:0] tok;
  } slot_t;
endpackage

// File: rtl/fsc_stage.sv
module fsc_stage
  import fsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  slot_t d,
  output slot_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    d.valid |=> q.valid); // R4
endmodule

// File: rtl/fsc_port_arb.sv
module fsc_port_arb
  import fsc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DATA_BASE = 12'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_avail,
  input  logic [ADDR_W-1:0] pc,
  input  slot_t             wb,
  output logic              fetch_go,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr
);
  logic wb_store;

  always_comb begin
    wb_store = wb.valid & wb.wr;
    fetch_go = instr_avail & ~wb_store;
    mem_en   = wb_store | fetch_go;
    mem_we   = wb_store;
    mem_addr = wb_store ? (DATA_BASE + wb.tok) : pc;
  end

  AST_WB_WINS: assert property (@(posedge clk) disable iff (rst)
    (wb.valid && wb.wr) |-> (mem_we && !fetch_go)); // R3
  AST_REG_NO_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (instr_avail && !(wb.valid && wb.wr)) |-> (fetch_go && mem_en && !mem_we)); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!instr_avail && !(wb.valid && wb.wr)) |-> !mem_en); // R7
  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    fetch_go |-> (mem_addr == pc && !mem_we)); // R2
endmodule

// File: rtl/fsc_counters.sv
module fsc_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] retired_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_cnt   <= '0;
      retired_cnt <= '0;
    end else begin
      cycle_cnt <= cycle_cnt + CNT_W'(1);
      if (retire) retired_cnt <= retired_cnt + CNT_W'(1);
    end
  end

  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
    retire |=> (retired_cnt == $past(retired_cnt) + CNT_W'(1))); // R8
  AST_RETIRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !retire |=> $stable(retired_cnt)); // R8
endmodule

// File: rtl/fetch_stall_ctrl.sv
module fetch_stall_ctrl
  import fsc_pkg::*;
#(
  parameter int                N_STAGE   = 4,
  parameter int                CNT_W     = 16,
  parameter logic [ADDR_W-1:0] DATA_BASE = 12'h800
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      instr_avail,
  input  logic                      instr_wr,
  output logic                      fetch_ack,
  output logic                      mem_en,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [N_STAGE-1:0]        stg_valid,
  output logic [N_STAGE*ADDR_W-1:0] stg_tok,
  output logic [CNT_W-1:0]          cycle_cnt,
  output logic [CNT_W-1:0]          retired_cnt
);
  localparam int LAST = N_STAGE - 1;

  logic [ADDR_W-1:0] pc_q;
  logic              fetch_go;
  slot_t             lane [N_STAGE];

  fsc_port_arb #(.DATA_BASE(DATA_BASE)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .instr_avail(instr_avail),
    .pc         (pc_q),
    .wb         (lane[LAST]),
    .fetch_go   (fetch_go),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (fetch_go) begin
      pc_q <= pc_q + ADDR_W'(1);
    end
  end

  assign lane[0] = '{valid: fetch_go, wr: instr_wr & fetch_go, tok: pc_q};

  for (genvar k = 0; k < LAST; k++) begin : g_pipe
    fsc_stage u_stage (
      .clk(clk),
      .rst(rst),
      .d  (lane[k]),
      .q  (lane[k+1])
    );
  end

  for (genvar k = 0; k < N_STAGE; k++) begin : g_out
    assign stg_valid[k]                  = lane[k].valid;
    assign stg_tok[k*ADDR_W +: ADDR_W]   = lane[k].tok;
  end

  assign fetch_ack = fetch_go;

  fsc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .retire     (lane[LAST].valid),
    .cycle_cnt  (cycle_cnt),
    .retired_cnt(retired_cnt)
  );

  AST_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    !fetch_go |=> !lane[1].valid); // R4
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fetch_go |=> $stable(pc_q)); // R5
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    fetch_go |=> (lane[1].tok == $past(pc_q))); // R5
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (lane[LAST].valid && lane[LAST].wr) |-> (mem_addr == DATA_BASE + lane[LAST].tok)); // R2
endmodule

// File: tb/tb_fetch_stall_ctrl.sv
module tb_fetch_stall_ctrl;
  localparam int AW = 12;
  localparam int CW = 16;
  localparam int NS = 4;
  localparam int DEPTH = 4096;
  localparam logic [AW-1:0] DB = 12'h800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_avail = 1'b0;
  logic instr_wr = 1'b0;
  logic fetch_ack, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [NS-1:0] stg_valid;
  logic [NS*AW-1:0] stg_tok;
  logic [CW-1:0] cycle_cnt, retired_cnt;

  fetch_stall_ctrl dut (
    .clk(clk), .rst(rst), .instr_avail(instr_avail), .instr_wr(instr_wr),
    .fetch_ack(fetch_ack), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .stg_valid(stg_valid), .stg_tok(stg_tok),
    .cycle_cnt(cycle_cnt), .retired_cnt(retired_cnt)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc, next_tok, ret_model, target, done_at;
  bit dv [DEPTH]; bit ev [DEPTH]; bit wv [DEPTH]; bit ww [DEPTH];
  int dt [DEPTH]; int et [DEPTH]; int wt [DEPTH];
  int fetch_cyc [DEPTH];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    instr_avail = 1'b0;
    instr_wr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      dv[i] = 0; ev[i] = 0; wv[i] = 0; ww[i] = 0; fetch_cyc[i] = -1;
    end
    rst = 1'b0;
    cyc = 0; next_tok = 0; ret_model = 0; done_at = -1;
    #1;
    chk("R1 stage valids", int'(stg_valid[3:1]), 0);
    chk("R1 cycle count", int'(cycle_cnt), 0);
    chk("R1 retired count", int'(retired_cnt), 0);
  endtask

  // Called at a falling edge; drives one cycle and checks it.
  task automatic step(input bit av, input bit wr, output bit go);
    bit wbst;
    instr_avail = av;
    instr_wr = wr;
    #1;
    wbst = wv[cyc] && ww[cyc];
    go = av && !wbst;
    chk(wbst ? "R3 fetch held" : (av ? "R6 fetch proceeds" : "R7 idle no fetch"),
        int'(fetch_ack), int'(go));
    chk(av || wbst ? "R2 mem_en" : "R7 mem_en", int'(mem_en), int'(go || wbst));
    chk("R2 mem_we", int'(mem_we), int'(wbst));
    if (wbst) chk("R3 store address", int'(mem_addr), int'(DB) + wt[cyc]);
    else if (go) chk("R6 fetch address", int'(mem_addr), next_tok);
    chk("R4 decode valid", int'(stg_valid[1]), int'(dv[cyc]));
    chk("R4 execute valid", int'(stg_valid[2]), int'(ev[cyc]));
    chk("R4 write valid", int'(stg_valid[3]), int'(wv[cyc]));
    if (go) chk("R9 fetch lane token", int'(stg_tok[0*AW +: AW]), next_tok);
    if (dv[cyc]) chk("R9 decode token", int'(stg_tok[1*AW +: AW]), dt[cyc]);
    if (ev[cyc]) chk("R9 execute token", int'(stg_tok[2*AW +: AW]), et[cyc]);
    if (wv[cyc]) chk("R5 write token order", int'(stg_tok[3*AW +: AW]), wt[cyc]);
    chk("R8 cycle count", int'(cycle_cnt), cyc);
    chk("R8 retired count", int'(retired_cnt), ret_model);
    if (go) begin
      dv[cyc+1] = 1; dt[cyc+1] = next_tok;
      ev[cyc+2] = 1; et[cyc+2] = next_tok;
      wv[cyc+3] = 1; wt[cyc+3] = next_tok; ww[cyc+3] = wr;
      fetch_cyc[next_tok] = cyc;
      next_tok++;
    end
    if (wv[cyc]) ret_model++;
    @(negedge clk);
    cyc++;
    if (done_at < 0 && int'(retired_cnt) == target) done_at = int'(cycle_cnt);
  endtask

  task automatic run_stream(input int n, input int wr_pct, input int av_pct,
                            input logic [15:0] pattern, input bit use_pat);
    int idx = 0;
    bit go;
    bit cur_wr;
    target = n;
    cur_wr = use_pat ? pattern[0] : (($urandom % 100) < wr_pct);
    while (idx < n && cyc < DEPTH - 16) begin
      step((($urandom % 100) < av_pct), cur_wr, go);
      if (go) begin
        idx++;
        cur_wr = use_pat ? pattern[idx % 16] : (($urandom % 100) < wr_pct);
      end
    end
    repeat (6) step(1'b0, 1'b0, go);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    // R8: five register-only instructions, 8 cycles
    do_reset();
    run_stream(5, 0, 100, 16'h0000, 1'b1);
    chk("R8 five non-storing total", done_at, 8);
    // R8/R3/R5: five storing instructions, 11 cycles, token 3 held to cycle 6
    do_reset();
    run_stream(5, 0, 100, 16'hFFFF, 1'b1);
    chk("R8 five storing total", done_at, 11);
    chk("R5 held token fetch cycle", fetch_cyc[3], 6);
    // R3: only the first stores, one-cycle hold
    do_reset();
    run_stream(5, 0, 100, 16'h0001, 1'b1);
    chk("R8 single store total", done_at, 9);
    // R7: no instruction offered at all
    do_reset();
    run_stream(0, 0, 0, 16'h0000, 1'b1);
    chk("R7 nothing retired", int'(retired_cnt), 0);
    // random streams
    do_reset();
    run_stream(300, 50, 70, 16'h0000, 1'b0);
    chk("R8 random retire total", int'(retired_cnt), 300);
    do_reset();
    run_stream(300, 90, 85, 16'h0000, 1'b0);
    chk("R8 store-heavy retire total", int'(retired_cnt), 300);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule